// File: doc/BRIEF.md
# Two-Class Column Arbiter for a Buffered Crossbar

This block serves one output port of a crossbar switch that has a buffer at every crosspoint. Each of the N crosspoint buffers in the output's column reports two bits: whether it holds anything, and whether the packet at its head is high priority. On every clock edge the arbiter registers a one-hot grant that names the buffer allowed to send its head packet to the output. High-priority heads always take precedence over low-priority ones. Within each class the choice is round-robin, and each class keeps its own pointer.

The block also contains an input-side queue selector for one input port. For each destination it has a high-priority and a low-priority virtual output queue. When the high queue holds data, the selector takes from it. The low queue is taken only when its high sibling is empty.

The grant is registered. A head that appears at a buffer therefore affects arbitration only from the next cycle on.

Top module: `prio_column_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `grant_vld`, `grant_is_hi` and `grant_oh` are cleared. Both round-robin pointers return to index 0.
- R2: After each edge with `rst_n` high, `grant_vld` is 1 exactly when at least one `xb_nonempty` bit was 1 at that edge. When valid, `grant_oh` has exactly one bit set, and that bit names a non-empty buffer. Otherwise `grant_oh` is all zero.
- R3: If any non-empty buffer has `xb_head_hi` = 1, the granted buffer is one of those high-priority buffers.
- R4: A buffer with a low-priority head is granted only when no non-empty buffer reports a high-priority head.
- R5: Among high-priority candidates, the winner is the first candidate met when scanning upward from the high pointer, wrapping from N_IN-1 to 0. After a high-class grant at index k, the high pointer becomes k+1, or 0 when k = N_IN-1.
- R6: The low class follows the same rule with its own pointer. Each pointer changes only on a grant of its own class.
- R7: `xb_head_hi` is ignored for a buffer whose `xb_nonempty` is 0. Such a buffer is never granted and never suppresses a low-priority grant.
- R8: `grant_is_hi` is 1 when the registered grant went to a high-priority head. It is 0 for a low-priority grant or when there is no grant.
- R9: For each destination d, `voq_take_hi[d]` = `voq_hi_ne[d]`. `voq_take_lo[d]` is 1 only when `voq_lo_ne[d]` is 1 and `voq_hi_ne[d]` is 0. The selector is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xb_nonempty | input | N_IN | Per crosspoint buffer: holds at least one packet |
| xb_head_hi | input | N_IN | Per crosspoint buffer: head packet is high priority |
| grant_oh | output | N_IN | Registered one-hot grant to a crosspoint buffer |
| grant_vld | output | 1 | Registered: a grant was issued |
| grant_is_hi | output | 1 | Registered: the grant went to a high-priority head |
| voq_hi_ne | input | N_DEST | Per destination: high-priority queue is non-empty |
| voq_lo_ne | input | N_DEST | Per destination: low-priority queue is non-empty |
| voq_take_hi | output | N_DEST | Per destination: take from the high-priority queue |
| voq_take_lo | output | N_DEST | Per destination: take from the low-priority queue |

## Verification
The bench builds the block with N_IN = 5 and N_DEST = 3. With five inputs the pointer width is three bits but only five of its eight values are legal. The wrap from index 4 back to 0 therefore does not come free from a power-of-two overflow, and both class pointers are exercised through that wrap. Three destinations keep the selector's full input space at 64 patterns, so every pattern is applied.

// File: rtl/pcol_pkg.sv
// Package: shared helpers for the two-class column arbiter.
// Assumes: indices are non-negative and below the column size.
package pcol_pkg;

    // Advance a round-robin index by one, wrapping at n.
    function automatic int wrap_next(input int idx, input int n);
        return (idx >= n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/pcol_rr_pick.sv
// Module: combinational round-robin picker.
// Scans req upward starting at ptr, wrapping at N. Returns the first set
// index and a found flag.
// Assumes: ptr < N (the caller keeps it in range).
module pcol_rr_pick #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic         found,
    output logic [W-1:0] idx
);

    // Find the first requester at or after the pointer.
    always_comb begin
        int cand;
        found = 1'b0;
        idx   = '0;
        cand  = 0;
        for (int off = 0; off < N; off++) begin
            cand = int'(ptr) + off;
            if (cand >= N) cand = cand - N;
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = W'(cand);
            end
        end
    end

endmodule

// File: rtl/pcol_voq_select.sv
// Module: input-side queue selector for one input port.
// For each destination, the high-priority queue is taken whenever it has
// data. The low-priority queue is taken only if its high sibling is empty.
// Assumes: the non-empty flags are current for this cycle.
module pcol_voq_select #(
    parameter int N_DEST = 4
) (
    input  logic [N_DEST-1:0] hi_ne,
    input  logic [N_DEST-1:0] lo_ne,
    output logic [N_DEST-1:0] take_hi,
    output logic [N_DEST-1:0] take_lo
);

    for (genvar d = 0; d < N_DEST; d++) begin : g_dest
        // Strict preference of the high queue for destination d.
        always_comb begin
            take_hi[d] = hi_ne[d];
            take_lo[d] = lo_ne[d] & ~hi_ne[d];
        end
    end

endmodule

// File: rtl/prio_column_arbiter.sv
// Module: two-class output arbiter for one crossbar column, plus an
// input-side queue selector.
// High-priority heads always win. Each class has its own round-robin
// pointer, and that pointer moves only when its class wins. The grant is
// registered, so a head becomes visible one cycle after it appears.
// Assumes: xb_head_hi is meaningful only where xb_nonempty is set.
module prio_column_arbiter
    import pcol_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_DEST = 4,
    localparam int W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   xb_nonempty,
    input  logic [N_IN-1:0]   xb_head_hi,
    output logic [N_IN-1:0]   grant_oh,
    output logic              grant_vld,
    output logic              grant_is_hi,
    input  logic [N_DEST-1:0] voq_hi_ne,
    input  logic [N_DEST-1:0] voq_lo_ne,
    output logic [N_DEST-1:0] voq_take_hi,
    output logic [N_DEST-1:0] voq_take_lo
);

    logic [N_IN-1:0] hi_req, lo_req;
    logic [W-1:0]    hi_ptr, lo_ptr;
    logic            hi_found, lo_found;
    logic [W-1:0]    hi_idx, lo_idx, win_idx;
    logic            any_req;

    // Split the requesters by the class of their head packet.
    always_comb begin
        hi_req = xb_nonempty & xb_head_hi;
        lo_req = xb_nonempty & ~xb_head_hi;
    end

    pcol_rr_pick #(.N(N_IN)) u_pick_hi (
        .req   (hi_req),
        .ptr   (hi_ptr),
        .found (hi_found),
        .idx   (hi_idx)
    );

    pcol_rr_pick #(.N(N_IN)) u_pick_lo (
        .req   (lo_req),
        .ptr   (lo_ptr),
        .found (lo_found),
        .idx   (lo_idx)
    );

    // Use the high-class winner if there is one, otherwise the low-class winner.
    always_comb begin
        any_req = hi_found | lo_found;
        win_idx = hi_found ? hi_idx : lo_idx;
    end

    // Register the grant and advance the pointer of the class that won.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_oh    <= '0;
            grant_vld   <= 1'b0;
            grant_is_hi <= 1'b0;
            hi_ptr      <= '0;
            lo_ptr      <= '0;
        end else begin
            grant_oh    <= any_req ? (N_IN'(1) << win_idx) : '0;
            grant_vld   <= any_req;
            grant_is_hi <= hi_found;
            if (hi_found)
                hi_ptr <= W'(wrap_next(int'(hi_idx), N_IN));
            else if (lo_found)
                lo_ptr <= W'(wrap_next(int'(lo_idx), N_IN));
        end
    end

    pcol_voq_select #(.N_DEST(N_DEST)) u_voq_sel (
        .hi_ne   (voq_hi_ne),
        .lo_ne   (voq_lo_ne),
        .take_hi (voq_take_hi),
        .take_lo (voq_take_lo)
    );

endmodule

// File: rtl/pcol_arb_chk.sv
// Checker: temporal properties of the column arbiter, attached by bind.
// Assumes: synchronous active-low reset.
module pcol_arb_chk #(
    parameter int N_IN   = 4,
    parameter int N_DEST = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_IN-1:0]   xb_nonempty,
    input logic [N_IN-1:0]   xb_head_hi,
    input logic [N_IN-1:0]   grant_oh,
    input logic              grant_vld,
    input logic              grant_is_hi,
    input logic [N_DEST-1:0] voq_hi_ne,
    input logic [N_DEST-1:0] voq_lo_ne,
    input logic [N_DEST-1:0] voq_take_hi,
    input logic [N_DEST-1:0] voq_take_lo
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !$past(rst_n) |-> (!grant_vld && grant_oh == '0 && !grant_is_hi)); // R1

    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (grant_vld == (|$past(xb_nonempty)))); // R2

    AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> ($countones(grant_oh) == 1)); // R2

    AST_GRANT_TO_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && grant_vld) |-> ((grant_oh & $past(xb_nonempty)) != '0)); // R2

    AST_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(xb_nonempty) & $past(xb_head_hi)) != '0))
            |-> (grant_is_hi && ((grant_oh & $past(xb_nonempty) & $past(xb_head_hi)) != '0))); // R3

    AST_LO_ONLY_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && grant_vld && !grant_is_hi)
            |-> (($past(xb_nonempty) & $past(xb_head_hi)) == '0)); // R4

    AST_IS_HI_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_is_hi |-> grant_vld); // R8

    AST_VOQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((voq_take_hi & voq_take_lo) == '0) && (voq_take_hi == voq_hi_ne)
            && ((voq_take_lo & ~voq_lo_ne) == '0)); // R9

endmodule

bind prio_column_arbiter pcol_arb_chk #(.N_IN(N_IN), .N_DEST(N_DEST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xb_nonempty (xb_nonempty),
    .xb_head_hi  (xb_head_hi),
    .grant_oh    (grant_oh),
    .grant_vld   (grant_vld),
    .grant_is_hi (grant_is_hi),
    .voq_hi_ne   (voq_hi_ne),
    .voq_lo_ne   (voq_lo_ne),
    .voq_take_hi (voq_take_hi),
    .voq_take_lo (voq_take_lo)
);

// File: tb/tb_prio_column_arbiter.sv
// Bench: behavioural reference model with two integer pointers, compared
// every cycle. Inputs change at the falling edge; outputs are checked at
// the next falling edge.
module tb_prio_column_arbiter;
    localparam int N  = 5;
    localparam int ND = 3;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  xb_ne = '0, xb_hi = '0;
    logic [N-1:0]  g_oh;
    logic          g_vld, g_hi;
    logic [ND-1:0] v_hi = '0, v_lo = '0, t_hi, t_lo;

    int total = 0;
    int bad   = 0;
    int m_hp  = 0;
    int m_lp  = 0;
    logic [N-1:0] e_oh;
    logic         e_vld, e_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_column_arbiter #(.N_IN(N), .N_DEST(ND)) dut (
        .clk(clk), .rst_n(rst_n),
        .xb_nonempty(xb_ne), .xb_head_hi(xb_hi),
        .grant_oh(g_oh), .grant_vld(g_vld), .grant_is_hi(g_hi),
        .voq_hi_ne(v_hi), .voq_lo_ne(v_lo),
        .voq_take_hi(t_hi), .voq_take_lo(t_lo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: scan a class from its pointer; return -1 when there is no candidate.
    function automatic int ref_scan(input logic [N-1:0] req, input int p);
        for (int k = 0; k < N; k++) begin
            int c = (p + k) % N;
            if (req[c]) return c;
        end
        return -1;
    endfunction

    // Apply one cycle of column inputs and compare the registered result.
    task automatic step(input logic [N-1:0] ne, input logic [N-1:0] hi, input string tag);
        int h, l, w;
        string t;
        xb_ne = ne;
        xb_hi = hi;
        h = ref_scan(ne & hi, m_hp);
        l = ref_scan(ne & ~hi, m_lp);
        w = (h >= 0) ? h : l;
        e_vld = (w >= 0);
        e_hi  = (h >= 0);
        e_oh  = e_vld ? (N'(1) << w) : '0;
        if (h >= 0) m_hp = (h + 1) % N;
        else if (l >= 0) m_lp = (l + 1) % N;
        @(negedge clk);
        t = (tag != "") ? tag : (e_hi ? "R5" : "R6");
        chk({t, "/R2 valid"}, 32'(g_vld), 32'(e_vld));
        chk({t, " grant"}, 32'(g_oh), 32'(e_oh));
        chk({t, "/R8 class"}, 32'(g_hi), 32'(e_hi));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: outputs cleared while reset is held, even with requests present.
        xb_ne = '1;
        xb_hi = 5'b00100;
        repeat (3) @(negedge clk);
        chk("R1 valid", 32'(g_vld), 0);
        chk("R1 grant", 32'(g_oh), 0);
        chk("R1 class", 32'(g_hi), 0);
        rst_n = 1'b1;
        // R1: both pointers start at 0.
        step('1, '0, "R1");
        step('1, '1, "R1");
        // R7: high flag on empty buffers is ignored.
        step('0, '1, "R7");
        step(5'b00010, 5'b11101, "R7");
        // R3: a single high head beats all low heads, repeatedly.
        step('1, 5'b00100, "R3");
        step('1, 5'b00100, "R3");
        step(5'b10001, 5'b10000, "R3");
        // R4: low heads only when no high head is present.
        step(5'b01010, 5'b00000, "R4");
        step(5'b11000, 5'b00000, "R4");
        // R5: full rotation of the high pointer, including the wrap.
        for (int i = 0; i < 7; i++) step('1, '1, "R5");
        // R6: the low pointer is held while high wins, then resumes.
        step('1, '0, "R6");
        step('1, 5'b00001, "R6");
        step('1, '0, "R6");
        for (int i = 0; i < 6; i++) step('1, '0, "R6");
        // Mixed random traffic.
        for (int i = 0; i < 400; i++) step(N'($urandom), N'($urandom), "");
        // R1: reset in mid-run clears the outputs and the pointers.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid valid", 32'(g_vld), 0);
        m_hp = 0;
        m_lp = 0;
        rst_n = 1'b1;
        step('1, '1, "R1");
        step('1, '0, "R1");
        // R9: every selector input pattern.
        for (int p = 0; p < (1 << (2 * ND)); p++) begin
            v_hi = ND'(p);
            v_lo = ND'(p >> ND);
            #1;
            chk("R9 take_hi", 32'(t_hi), 32'(v_hi));
            chk("R9 take_lo", 32'(t_lo), 32'(v_lo & ~v_hi));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule